// File: doc/BRIEF.md
# CAN Receive Identifier Acceptance Filter

This block sits on the receive side of a CAN controller. Each frame that arrives is placed in a background receive buffer, and the block then decides whether the CPU should see it. Two independent acceptance banks are provided. Each bank holds four acceptance-code bytes and four mask bytes. The four identifier bytes of the buffered frame are compared against each bank bit by bit. A mask bit set to 1 makes its position a don't-care.

Bit 3 of identifier byte 1 marks an extended identifier. For an extended frame, all four bytes of a bank take part in the comparison. For a standard frame, only bytes 0 and 1 are compared. If either bank matches, the frame is accepted and a one-cycle receive-accept pulse is raised. A per-bank hit vector reports which banks matched. If no bank matches, no pulse is raised, and the next reception simply overwrites the buffer.

The filter registers sit behind a byte-wide register port. They can be read at any time. Writes take effect only while both the initialization request and the initialization acknowledge inputs are high.

Top module: `can_id_filter`

## Requirements
- R1: After reset, every code and mask register reads 0x00, `rx_accept` is 0 and `rx_hit` is 0.
- R2: For bank b (0 or 1) and byte n (0..3), the code register is at address 0x10+8*b+n and the mask register is at 0x14+8*b+n. Reads are combinational and allowed at any time. Any other address reads 0x00.
- R3: A write with `reg_wr`=1 updates the addressed register only when `init_req`=1 and `init_ack`=1. Any other write leaves every register unchanged.
- R4: An identifier bit whose mask bit is 0 must equal the code bit. An identifier bit whose mask bit is 1 is ignored.
- R5: When `rx_id[11]` (bit 3 of identifier byte 1) is 1, all four identifier bytes are compared. Byte n is `rx_id[8n+7:8n]`.
- R6: When `rx_id[11]` is 0, only identifier bytes 0 and 1 are compared. Bytes 2 and 3 have no effect.
- R7: `rx_hit[b]` is 1 exactly when bank b matches. A frame is accepted when at least one bank matches.
- R8: `rx_accept` is a one-cycle pulse in the cycle after the clock edge that samples `rx_full`=1 for an accepted frame. `rx_hit` updates on that same edge and holds until the next strobe.
- R9: A frame that matches neither bank produces no `rx_accept` pulse, and `rx_hit` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| init_req | input | 1 | Initialization mode request flag |
| init_ack | input | 1 | Initialization mode acknowledge flag |
| reg_addr | input | 6 | Register byte address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| rx_full | input | 1 | Background buffer holds a new frame (one-cycle strobe) |
| rx_id | input | 32 | Identifier bytes 0..3 of the buffered frame, byte n at [8n+7:8n] |
| rx_accept | output | 1 | One-cycle pulse: the frame passed the filter |
| rx_hit | output | 2 | Per-bank match result of the latest frame |

## Verification
The assertions assume that `rx_full` is a strobe and that `rx_id` is valid in the cycle the strobe is sampled. They also assume reset is asserted before the first strobe or write, so the history that `$past` looks at is clean. The bench keeps to these assumptions. It drives every input on the falling edge, raises `rx_full` for exactly one cycle per frame with `rx_id` set up alongside it, and returns the strobe low before sampling the result. Register writes are driven as single-cycle strobes, both inside and outside the acknowledged initialization window.

// File: rtl/can_filt_pkg.sv
package can_filt_pkg;
    localparam int unsigned CF_BYTE_W    = 8;
    localparam int unsigned CF_ID_BYTES  = 4;
    localparam int unsigned CF_STD_BYTES = 2;
    localparam int unsigned CF_IDE_BYTE  = 1;
    localparam int unsigned CF_IDE_BIT   = 3;
    localparam int unsigned CF_BASE_ADDR = 16;

    typedef logic [CF_BYTE_W-1:0] cf_byte_t;
endpackage

// File: rtl/can_filt_regs.sv
module can_filt_regs
    import can_filt_pkg::*;
#(
    parameter int unsigned NUM_BANKS = 2,
    parameter int unsigned ADDR_W    = 6,
    localparam int unsigned STRIDE   = 2 * CF_ID_BYTES,
    localparam int unsigned FLAT_W   = NUM_BANKS * CF_ID_BYTES * CF_BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  cf_byte_t          wdata,
    output cf_byte_t          rdata,
    output logic [FLAT_W-1:0] code_flat,
    output logic [FLAT_W-1:0] mask_flat
);
    typedef struct packed {
        logic [FLAT_W-1:0] code;
        logic [FLAT_W-1:0] mask;
    } regs_t;

    regs_t regs_d, regs_q;
    logic [NUM_BANKS*CF_ID_BYTES-1:0] code_sel, mask_sel;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        for (genvar n = 0; n < CF_ID_BYTES; n++) begin : g_byte
            localparam int unsigned CODE_A = CF_BASE_ADDR + STRIDE * b + n;
            localparam int unsigned MASK_A = CODE_A + CF_ID_BYTES;
            assign code_sel[b*CF_ID_BYTES+n] = (addr == ADDR_W'(CODE_A));
            assign mask_sel[b*CF_ID_BYTES+n] = (addr == ADDR_W'(MASK_A));
        end
    end

    always_comb begin
        regs_d = regs_q;
        rdata  = '0;
        for (int i = 0; i < NUM_BANKS * CF_ID_BYTES; i++) begin
            if (code_sel[i]) begin
                rdata = regs_q.code[i*CF_BYTE_W +: CF_BYTE_W];
                if (wr_en) regs_d.code[i*CF_BYTE_W +: CF_BYTE_W] = wdata;
            end
            if (mask_sel[i]) begin
                rdata = regs_q.mask[i*CF_BYTE_W +: CF_BYTE_W];
                if (wr_en) regs_d.mask[i*CF_BYTE_W +: CF_BYTE_W] = wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign code_flat = regs_q.code;
    assign mask_flat = regs_q.mask;
endmodule

// File: rtl/can_filt_bank_match.sv
module can_filt_bank_match
    import can_filt_pkg::*;
#(
    localparam int unsigned ID_W = CF_ID_BYTES * CF_BYTE_W
) (
    input  logic [ID_W-1:0] id,
    input  logic [ID_W-1:0] code,
    input  logic [ID_W-1:0] mask,
    output logic            hit
);
    logic [CF_ID_BYTES-1:0] byte_ok;
    logic                   extended;

    for (genvar n = 0; n < CF_ID_BYTES; n++) begin : g_cmp
        logic [CF_BYTE_W-1:0] diff;
        assign diff = (id[n*CF_BYTE_W +: CF_BYTE_W] ^ code[n*CF_BYTE_W +: CF_BYTE_W])
                      & ~mask[n*CF_BYTE_W +: CF_BYTE_W];
        if (n < CF_STD_BYTES) begin : g_always
            assign byte_ok[n] = (diff == '0);
        end else begin : g_ext_only
            assign byte_ok[n] = (diff == '0) || !extended;
        end
    end

    assign extended = id[CF_IDE_BYTE*CF_BYTE_W + CF_IDE_BIT];
    assign hit      = &byte_ok;
endmodule

// File: rtl/can_id_filter.sv
module can_id_filter
    import can_filt_pkg::*;
#(
    parameter int unsigned NUM_BANKS = 2,
    parameter int unsigned ADDR_W    = 6,
    localparam int unsigned ID_W     = CF_ID_BYTES * CF_BYTE_W,
    localparam int unsigned FLAT_W   = NUM_BANKS * ID_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 init_req,
    input  logic                 init_ack,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic                 reg_wr,
    input  logic [CF_BYTE_W-1:0] reg_wdata,
    output logic [CF_BYTE_W-1:0] reg_rdata,
    input  logic                 rx_full,
    input  logic [ID_W-1:0]      rx_id,
    output logic                 rx_accept,
    output logic [NUM_BANKS-1:0] rx_hit
);
    typedef struct packed {
        logic [NUM_BANKS-1:0] hit;
        logic                 accept;
    } dec_t;

    logic [FLAT_W-1:0]    code_flat, mask_flat;
    logic [NUM_BANKS-1:0] bank_hit;
    logic                 wr_ok;
    dec_t                 dec_d, dec_q;

    assign wr_ok = reg_wr && init_req && init_ack;

    can_filt_regs #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_ok),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .rdata     (reg_rdata),
        .code_flat (code_flat),
        .mask_flat (mask_flat)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_match
        can_filt_bank_match u_match (
            .id   (rx_id),
            .code (code_flat[b*ID_W +: ID_W]),
            .mask (mask_flat[b*ID_W +: ID_W]),
            .hit  (bank_hit[b])
        );
    end

    always_comb begin
        dec_d        = dec_q;
        dec_d.accept = 1'b0;
        if (rx_full) begin
            dec_d.hit    = bank_hit;
            dec_d.accept = |bank_hit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dec_q <= '0;
        else        dec_q <= dec_d;
    end

    assign rx_accept = dec_q.accept;
    assign rx_hit    = dec_q.hit;
endmodule

// File: rtl/can_filt_chk.sv
module can_filt_chk #(
    parameter int unsigned NUM_BANKS = 2,
    parameter int unsigned FLAT_W    = 64
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 init_req,
    input logic                 init_ack,
    input logic                 reg_wr,
    input logic                 rx_full,
    input logic                 rx_accept,
    input logic [NUM_BANKS-1:0] rx_hit,
    input logic [FLAT_W-1:0]    code_flat,
    input logic [FLAT_W-1:0]    mask_flat
);
    assert_locked_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !(init_req && init_ack)) |=> ($stable(code_flat) && $stable(mask_flat)));

    assert_accept_after_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_accept |-> $past(rx_full));

    assert_hit_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_full |=> $stable(rx_hit));

    assert_accept_has_hit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_accept |-> (rx_hit != '0));

    assert_drop_no_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_full && !rx_accept) |=> (rx_hit == '0) == !rx_accept);
endmodule

bind can_id_filter can_filt_chk #(.NUM_BANKS(NUM_BANKS), .FLAT_W(FLAT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .init_req  (init_req),
    .init_ack  (init_ack),
    .reg_wr    (reg_wr),
    .rx_full   (rx_full),
    .rx_accept (rx_accept),
    .rx_hit    (rx_hit),
    .code_flat (code_flat),
    .mask_flat (mask_flat)
);

// File: tb/tb_can_id_filter.sv
module tb_can_id_filter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        init_req = 1'b0, init_ack = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        rx_full = 1'b0;
    logic [31:0] rx_id = '0;
    logic        rx_accept;
    logic [1:0]  rx_hit;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    can_id_filter dut (
        .clk(clk), .rst_n(rst_n), .init_req(init_req), .init_ack(init_ack),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .rx_full(rx_full), .rx_id(rx_id),
        .rx_accept(rx_accept), .rx_hit(rx_hit)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [5:0] a, input logic [7:0] exp);
        reg_addr = a;
        #1;
        check(req, {24'h0, reg_rdata}, {24'h0, exp});
    endtask

    // frame bytes b0..b3 placed at rx_id[8n+7:8n]
    task automatic frame(input string req, input logic [7:0] b0, b1, b2, b3,
                         input logic [1:0] exp_hit);
        @(negedge clk);
        rx_full = 1'b1; rx_id = {b3, b2, b1, b0};
        @(negedge clk);
        rx_full = 1'b0;
        check({req, " accept"}, {31'h0, rx_accept}, {31'h0, |exp_hit});
        check({req, " hit"}, {30'h0, rx_hit}, {30'h0, exp_hit});
        @(negedge clk);
        check({req, " pulse end R8"}, {31'h0, rx_accept}, 32'h0);
        check({req, " hit held R8"}, {30'h0, rx_hit}, {30'h0, exp_hit});
    endtask

    task automatic t_reset_R1;
        for (int a = 16; a < 32; a++) rd_check("R1 reset reg", 6'(a), 8'h00);
        check("R1 accept", {31'h0, rx_accept}, 32'h0);
        check("R1 hit", {30'h0, rx_hit}, 32'h0);
    endtask

    task automatic t_gating_R3;
        init_req = 1'b1; init_ack = 1'b0;
        wr(6'h10, 8'hAA);
        rd_check("R3 req only", 6'h10, 8'h00);
        init_req = 1'b0; init_ack = 1'b1;
        wr(6'h14, 8'h55);
        rd_check("R3 ack only", 6'h14, 8'h00);
        init_req = 1'b1;
        wr(6'h10, 8'hAA);
        rd_check("R3 open write", 6'h10, 8'hAA);
    endtask

    task automatic t_program_R2;
        init_req = 1'b1; init_ack = 1'b1;
        // bank0 code 12 38 56 78, mask 00 00 00 0F
        wr(6'h10, 8'h12); wr(6'h11, 8'h38); wr(6'h12, 8'h56); wr(6'h13, 8'h78);
        wr(6'h14, 8'h00); wr(6'h15, 8'h00); wr(6'h16, 8'h00); wr(6'h17, 8'h0F);
        // bank1 code A0 20 FF FF, mask 00 00 00 00
        wr(6'h18, 8'hA0); wr(6'h19, 8'h20); wr(6'h1A, 8'hFF); wr(6'h1B, 8'hFF);
        wr(6'h1C, 8'h00); wr(6'h1D, 8'h00); wr(6'h1E, 8'h00); wr(6'h1F, 8'h00);
        init_req = 1'b0; init_ack = 1'b0;
        rd_check("R2 bank0 code3", 6'h13, 8'h78);
        rd_check("R2 bank0 mask3", 6'h17, 8'h0F);
        rd_check("R2 bank1 code0", 6'h18, 8'hA0);
        rd_check("R2 bank1 code2", 6'h1A, 8'hFF);
        rd_check("R2 unmapped", 6'h08, 8'h00);
        wr(6'h11, 8'h00);
        rd_check("R3 locked write", 6'h11, 8'h38);
    endtask

    task automatic t_frames;
        frame("R5 R4 ext masked nibble", 8'h12, 8'h38, 8'h56, 8'h7C, 2'b01);
        frame("R9 ext byte3 miss", 8'h12, 8'h38, 8'h56, 8'h88, 2'b00);
        frame("R5 ext byte2 miss", 8'h12, 8'h38, 8'h57, 8'h78, 2'b00);
        frame("R6 std ignores bytes2-3", 8'hA0, 8'h20, 8'h11, 8'h22, 2'b10);
        frame("R4 std bit miss", 8'hA1, 8'h20, 8'hFF, 8'hFF, 2'b00);
    endtask

    task automatic t_both_R7;
        init_req = 1'b1; init_ack = 1'b1;
        wr(6'h18, 8'h12); wr(6'h19, 8'h38); wr(6'h1A, 8'h56); wr(6'h1B, 8'h70);
        wr(6'h1F, 8'h0F);
        init_req = 1'b0; init_ack = 1'b0;
        frame("R7 both banks", 8'h12, 8'h38, 8'h56, 8'h7C, 2'b11);
    endtask

    initial begin
        fork
            begin
                #20 rst_n = 1'b1;
                @(negedge clk);
                t_reset_R1;
                t_gating_R3;
                t_program_R2;
                t_frames;
                t_both_R7;
            end
            begin
                repeat (100000) @(posedge clk);
                errors++; checks++;
                $display("FAIL watchdog expired");
            end
        join_any
        disable fork;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule